// File: doc/BRIEF.md
# Debounced Pin Edge Interrupt Detector

The block monitors a bank of general-purpose input pins and flags debounced level changes as interrupt requests. Every pin is first brought into the clock domain through two flops. It is then sampled at a rate set by one prescaler that all pins share. A new level is accepted only after two successive samples agree. An accepted 0-to-1 or 1-to-0 change sets that pin's pending flag when the matching edge enable is on. The flag stays set until software clears it by writing a one. One combined interrupt line is the OR of all flags.

The prescaler counts either every system clock or only on cycles that carry a pulse on a slow tick input, which stands in for a low-speed oscillator. A 4-bit select picks a period of 2^v counting clocks. A power-mode input chooses one of two modes. In one mode each pin's detector is enabled only when one of that pin's edge enables is set. In the other mode every detector runs all the time. The choice affects power only and never changes which flags are set.

Top module: `gpio_edge_irq`

## Requirements
- R1: With source select 0, a select value v makes the shared sampling strobe fire once every 2^v system clocks. v=0 samples every clock and v=15 samples once per 32768 clocks.
- R2: With source select 1, the prescaler advances only in cycles where the slow tick input is high. No sample is taken in any other cycle.
- R3: In any cycle where the select value or the source select differs from its value in the previous cycle, no sample is taken and the prescaler restarts from zero. A half-confirmed level change is also discarded.
- R4: A level change is accepted only when two consecutive samples of the synchronised pin agree on the new level. A pulse shorter than one sampling period sets no flag.
- R5: With v=0 and the system clock, a pin change captured at a clock edge sets its pending flag at the fourth clock edge counted from that one, and not before.
- R6: The 32-bit enable word holds pin n's rising enable in bit n+16. An accepted 0-to-1 change sets pending[n] only when that bit is 1.
- R7: The enable word holds pin n's falling enable in bit n. An accepted 1-to-0 change sets pending[n] only when that bit is 1.
- R8: While both of a pin's enables are 0, its accepted level keeps tracking the pin. Setting an enable later therefore produces no flag for a change that happened earlier.
- R9: A pending flag stays set until a clock edge at which the same bit of the clear mask is 1. Clearing one bit leaves the other bits unchanged. A new edge arriving in the clearing cycle wins, and the flag stays set.
- R10: The interrupt output is 1 exactly when at least one pending flag is set.
- R11: The always-on mode input has no effect on which pending flags are set.
- R12: After reset, no flag is pending, the interrupt output is 0, and each pin's accepted level equals the pin's level during reset. A pin held high through reset gives no rising flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Raw pin levels |
| sampleSel | input | 4 | Sampling period select, period 2^v |
| slowSrc | input | 1 | Prescaler source: 0 system clock, 1 slow tick |
| slowTick | input | 1 | One-cycle pulse per low-speed clock period |
| alwaysOn | input | 1 | 1: all detectors always active; 0: only enabled detectors active |
| edgeEn | input | 32 | Falling enables in bits [n], rising enables in bits [n+16] |
| clearMask | input | NUM_PINS | Write-one-to-clear strobe per pending flag |
| pending | output | NUM_PINS | Per-pin pending edge flags |
| irq | output | 1 | OR of all pending flags |

## Verification
A prescaler that miscounts shows up as a wrong time at which a flag appears. At v=4 the bench brackets a rise between 18 and 36 clocks, and at v=0 it pins the rise to exactly four edges. A corrupted accepted level appears as a missing flag, or as a spurious one, on the next confirmed change of that pin, usually within two sampling periods. A flag that is wrongly cleared or held shows at the first check after the clear strobe, one cycle later.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int SEL_W = 4;
  localparam int EN_W = 32;
  localparam int RISE_OFS = 16;

  typedef struct packed {
    logic sampleEn;
    logic restart;
  } smpStrobe_t;
endpackage

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
  import gpio_edge_pkg::*;
#(
  parameter int SELW = SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sampleSel,
  input  logic            slowSrc,
  input  logic            slowTick,
  output smpStrobe_t      strb
);
  localparam int CNT_W = (1 << SELW) - 1;

  logic [SELW-1:0]  selQ;
  logic             srcQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic             countTick;
  logic             restart;
  logic             atLast;

  always_comb begin
    restart   = (sampleSel != selQ) || (slowSrc != srcQ);
    countTick = slowSrc ? slowTick : 1'b1;
    lastCnt   = ~({CNT_W{1'b1}} << sampleSel);
    atLast    = (cnt == lastCnt);
    strb.restart  = restart;
    strb.sampleEn = countTick && !restart && atLast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ <= '0;
      srcQ <= 1'b0;
      cnt  <= '0;
    end else begin
      selQ <= sampleSel;
      srcQ <= slowSrc;
      if (restart)        cnt <= '0;
      else if (countTick) cnt <= atLast ? '0 : cnt + 1'b1;
    end
  end

  // R2: with the slow source, no sample without a tick
  a_r2_slow_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (slowSrc && !slowTick) |-> !strb.sampleEn);

  // R3: a sample never directly follows a select change
  a_r3_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.sampleEn && sampleSel != '0 && !slowSrc) |-> $stable(sampleSel));
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  smpStrobe_t          strb,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [EN_W-1:0]     edgeEn,
  input  logic                alwaysOn,
  input  logic [NUM_PINS-1:0] clearMask,
  output logic [NUM_PINS-1:0] pending
);
  logic [NUM_PINS-1:0] sync1, sync2, prevSmp, accepted;
  logic [NUM_PINS-1:0] acceptMask, riseHit, fallHit, setVec;
  logic [1:0]          settleCnt;
  logic                settled;

  always_comb begin
    settled    = (settleCnt == 2'd3);
    acceptMask = (settled && strb.sampleEn) ? ~(sync2 ^ prevSmp) : '0;
    riseHit    = acceptMask & sync2 & ~accepted;
    fallHit    = acceptMask & ~sync2 & accepted;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseEn, fallEn, detActive;
    assign riseEn    = edgeEn[RISE_OFS + i];
    assign fallEn    = edgeEn[i];
    assign detActive = alwaysOn | riseEn | fallEn;
    assign setVec[i] = detActive & ((riseHit[i] & riseEn) | (fallHit[i] & fallEn));

    // R8: a detector with both enables off sets nothing
    a_r8_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(riseEn || fallEn) |=> !$rose(pending[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      prevSmp   <= '0;
      accepted  <= '0;
      settleCnt <= '0;
      pending   <= '0;
    end else begin
      sync1 <= pinIn;
      sync2 <= sync1;
      if (!settled) begin
        settleCnt <= settleCnt + 2'd1;
        accepted  <= sync2;
        prevSmp   <= sync2;
      end else if (strb.restart) begin
        prevSmp <= accepted;
      end else if (strb.sampleEn) begin
        prevSmp  <= sync2;
        accepted <= (accepted & ~acceptMask) | (sync2 & acceptMask);
      end
      pending <= (pending & ~clearMask) | setVec;
    end
  end

  // R4: accepted levels move only on a sample strobe once settled
  a_r4_accept_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !strb.sampleEn) |=> $stable(accepted));

  // R5: a new flag always follows a sample strobe
  a_r5_set_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & ~$past(pending))) |-> $past(strb.sampleEn));

  // R9: flags drop only where the clear mask was set
  a_r9_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & $past(pending) & ~$past(clearMask)) == ($past(pending) & ~$past(clearMask))));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [SEL_W-1:0]    sampleSel,
  input  logic                slowSrc,
  input  logic                slowTick,
  input  logic                alwaysOn,
  input  logic [EN_W-1:0]     edgeEn,
  input  logic [NUM_PINS-1:0] clearMask,
  output logic [NUM_PINS-1:0] pending,
  output logic                irq
);
  smpStrobe_t strb;

  gpio_edge_ctl #(.SELW(SEL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sampleSel(sampleSel),
    .slowSrc  (slowSrc),
    .slowTick (slowTick),
    .strb     (strb)
  );

  gpio_edge_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .pinIn    (pinIn),
    .edgeEn   (edgeEn),
    .alwaysOn (alwaysOn),
    .clearMask(clearMask),
    .pending  (pending)
  );

  assign irq = |pending;

  // R10: no interrupt unless some flag stays pending
  a_r10_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !irq);
endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/100ps
module gpio_edge_irq_tb;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [3:0]    sampleSel = '0;
  logic          slowSrc = 1'b0;
  logic          slowTick = 1'b0;
  logic          alwaysOn = 1'b0;
  logic [31:0]   edgeEn = '0;
  logic [NP-1:0] clearMask = '0;
  logic [NP-1:0] pending;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NP-1:0] exp;
    string         tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .sampleSel(sampleSel),
    .slowSrc(slowSrc), .slowTick(slowTick), .alwaysOn(alwaysOn),
    .edgeEn(edgeEn), .clearMask(clearMask), .pending(pending), .irq(irq)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pending !== it.exp || irq !== (|it.exp)) begin
        fails++;
        $display("FAIL %s: pending=%h irq=%b expected pending=%h irq=%b",
                 it.tag, pending, irq, it.exp, |it.exp);
      end
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectP(input logic [NP-1:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic clearAll();
    clearMask = '1;
    ticks(1);
    clearMask = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    // R12: pin3 high through reset with its rising enable on
    pinIn[3] = 1'b1;
    edgeEn[19] = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    expectP('0, "R12 reset state");
    ticks(8);
    expectP('0, "R12 level at reset is accepted, no rise");

    // R5 R6: exact latency of a rising flag on pin0
    edgeEn[16] = 1'b1;
    pinIn[0] = 1'b1;
    ticks(3);
    expectP('0, "R5 not before fourth edge");
    ticks(1);
    expectP(16'h0001, "R5 R6 rising flag at fourth edge, R10 irq");

    // R9: clear
    clearAll();
    expectP('0, "R9 write-one clear");

    // R4: one-cycle glitch on pin1 rejected
    edgeEn[17] = 1'b1;
    pinIn[1] = 1'b1;
    ticks(1);
    pinIn[1] = 1'b0;
    ticks(8);
    expectP('0, "R4 short pulse ignored");

    // R6 R7: pin2 rise not enabled, fall enabled
    edgeEn[2] = 1'b1;
    pinIn[2] = 1'b1;
    ticks(6);
    expectP('0, "R6 rise without rising enable");
    pinIn[2] = 1'b0;
    ticks(6);
    expectP(16'h0004, "R7 falling flag");
    clearAll();

    // R8: gated pin5 keeps tracking
    pinIn[5] = 1'b1;
    ticks(6);
    edgeEn[21] = 1'b1;
    ticks(6);
    expectP('0, "R8 no false edge on enabling");
    pinIn[5] = 1'b0;
    ticks(6);
    expectP('0, "R8 fall not enabled");
    pinIn[5] = 1'b1;
    ticks(6);
    expectP(16'h0020, "R8 later rise flagged");

    // R9: selective clear
    edgeEn[0] = 1'b1;
    pinIn[0] = 1'b0;
    ticks(6);
    expectP(16'h0021, "R7 pin0 fall adds to pending");
    clearMask = 16'h0020;
    ticks(1);
    clearMask = '0;
    expectP(16'h0001, "R9 other bits unaffected by clear");
    clearAll();

    // R11: always-on mode without enables sets nothing
    alwaysOn = 1'b1;
    pinIn[6] = 1'b1;
    ticks(6);
    pinIn[6] = 1'b0;
    ticks(6);
    expectP('0, "R11 always-on gives no flag");
    alwaysOn = 1'b0;

    // R1: period 16
    sampleSel = 4'd4;
    ticks(5);
    edgeEn[23] = 1'b1;
    pinIn[7] = 1'b1;
    ticks(18);
    expectP('0, "R1 too early at period 16");
    ticks(18);
    expectP(16'h0080, "R1 flag within two periods");
    clearAll();

    // R3: select keeps changing, no sample ever taken
    edgeEn[24] = 1'b1;
    pinIn[8] = 1'b1;
    for (int k = 0; k < 20; k++) begin
      sampleSel = 4'd3;
      ticks(3);
      sampleSel = 4'd2;
      ticks(3);
    end
    expectP('0, "R3 restart blocks sampling");
    ticks(20);
    expectP(16'h0100, "R3 flag once select holds");
    clearAll();

    // R2: slow source
    sampleSel = 4'd0;
    slowSrc = 1'b1;
    ticks(3);
    edgeEn[25] = 1'b1;
    pinIn[9] = 1'b1;
    ticks(40);
    expectP('0, "R2 no sample without slow tick");
    for (int k = 0; k < 3; k++) begin
      slowTick = 1'b1;
      ticks(1);
      slowTick = 1'b0;
      ticks(2);
    end
    expectP(16'h0200, "R2 flag after slow ticks");
    clearAll();

    // R9: new edge wins over a simultaneous clear
    slowSrc = 1'b0;
    ticks(4);
    edgeEn[26] = 1'b1;
    pinIn[10] = 1'b1;
    ticks(3);
    clearMask = 16'h0400;
    ticks(1);
    clearMask = '0;
    expectP(16'h0400, "R9 set beats clear");

    ticks(2);
    done = 1'b1;
    summary();
  end
endmodule